// File: doc/BRIEF.md
# Masked Packed 64-bit Subtract Unit

This block is one execution slice of a vector unit. It subtracts a second 512-bit source from a first 512-bit source, treating each source as eight 64-bit elements. Each element is computed on its own, and a borrow never crosses from one element into the next. The active vector length can be 128, 256 or 512 bits. An encoding-mode input selects how the result bits outside the computed elements are filled.

In the masked mode, an 8-bit write mask decides which elements take the difference. An element whose mask bit is clear either keeps the old destination value or becomes zero, depending on the policy input. The second source can also be a single 64-bit scalar repeated across all elements. The result goes into a register once, and a valid strobe marks it one clock after the request.

The unit produces no status flags. Decode, memory access and register storage happen elsewhere.

Top module: `masked_qsub`

## Requirements
- R1: Each computed element equals the first-source element minus the second-source element modulo 2^64, so 0 minus 1 gives all ones and the most negative value minus 1 gives the most positive value.
- R2: Element j occupies bits [64j+63:64j]. `vec_len` 0 selects 2 active elements, 1 selects 4, and 2 or 3 select 8. `enc_mode` 0 is legacy, 1 is plain vector, and 2 or 3 are masked.
- R3: In legacy mode only elements 0 and 1 are computed, whatever `vec_len` is, and bits 511:128 of the result take the old destination value.
- R4: In plain vector mode every active element is computed and the write mask has no effect.
- R5: In masked mode an active element is computed when its `wr_mask` bit is 1 or when `mask_on` is 0.
- R6: In masked mode, with `mask_on`=1 and `zero_fill`=0, an active element whose mask bit is 0 takes the old destination element.
- R7: In masked mode, with `mask_on`=1 and `zero_fill`=1, an active element whose mask bit is 0 becomes 0.
- R8: In plain vector and masked modes, all bits above the active vector length are 0, and mask bits at inactive positions have no effect.
- R9: In masked mode, with `bcast`=1 and `src_b_mem`=1, every computed element subtracts `src_b[63:0]`.
- R10: The broadcast request has no effect when `src_b_mem` is 0, or in legacy or plain vector mode.
- R11: `res_valid` is 1 exactly in the cycle after a cycle with `in_valid`=1. The result is held unchanged while `in_valid` is 0.
- R12: While `rst_n` is low, `result` and `res_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Request strobe; the operands are captured on this cycle |
| src_a | input | 512 | Minuend vector |
| src_b | input | 512 | Subtrahend vector; bits 63:0 are the broadcast scalar |
| dst_old | input | 512 | Previous destination value |
| wr_mask | input | 8 | Per-element write mask |
| mask_on | input | 1 | Write masking enabled (masked mode only) |
| zero_fill | input | 1 | 1: masked-off elements become 0; 0: they keep `dst_old` |
| bcast | input | 1 | Broadcast request for the second source |
| src_b_mem | input | 1 | Second source is marked as coming from memory |
| enc_mode | input | 2 | 0 legacy, 1 plain vector, 2/3 masked |
| vec_len | input | 2 | 0: 128 bits, 1: 256 bits, 2/3: 512 bits |
| result | output | 512 | Registered result |
| res_valid | output | 1 | Result strobe |

## Verification
The bench targets the places where the three fill rules meet. These are legacy mode with a 512-bit length, which must still keep the upper 384 bits, and masked mode with mask bits set above a 128-bit length, which must still produce zero. A design that took its limit from `vec_len` in legacy mode, or one that honoured out-of-range mask bits, would show computed differences where old data or zeros belong.

Broadcast is requested with the memory flag clear and in the unmasked modes. A design that broadcast anyway would repeat element 0 of the second source across the vector. Wrap corners catch a subtractor that saturates or lets a borrow cross an element boundary. An idle cycle after a result catches a register that reloads without a request.

// File: rtl/psq_pkg.sv
package psq_pkg;
  localparam int unsigned ELEM_W    = 64;
  localparam int unsigned MAX_ELEMS = 8;
  localparam int unsigned LEG_ELEMS = 2;

  typedef enum logic [1:0] {
    ENC_LEGACY = 2'd0,
    ENC_PLAIN  = 2'd1,
    ENC_MASKED = 2'd2,
    ENC_MASKX  = 2'd3
  } enc_e;
endpackage

// File: rtl/psq_ctrl.sv
// Per-element action decode: compute, zero, or keep old (neither flag).
module psq_ctrl #(
  parameter int unsigned N_ELEMS = psq_pkg::MAX_ELEMS
) (
  input  logic [1:0]         enc_mode,
  input  logic [1:0]         vec_len,
  input  logic [N_ELEMS-1:0] wr_mask,
  input  logic               mask_on,
  input  logic               zero_fill,
  input  logic               bcast,
  input  logic               src_b_mem,
  output logic [N_ELEMS-1:0] do_sub,
  output logic [N_ELEMS-1:0] do_zero,
  output logic               use_scalar
);
  import psq_pkg::*;

  localparam int unsigned LIM_128 = LEG_ELEMS;
  localparam int unsigned LIM_256 = 2 * LEG_ELEMS;

  int unsigned lim;
  logic        is_masked;

  always_comb begin
    is_masked  = (enc_mode == ENC_MASKED) || (enc_mode == ENC_MASKX);
    use_scalar = is_masked && bcast && src_b_mem;
    if (enc_mode == ENC_LEGACY) lim = LIM_128;
    else if (vec_len == 2'd0)   lim = LIM_128;
    else if (vec_len == 2'd1)   lim = LIM_256;
    else                        lim = N_ELEMS;
  end

  for (genvar j = 0; j < N_ELEMS; j++) begin : g_act
    logic active;
    assign active = (j < lim);
    always_comb begin
      do_sub[j]  = 1'b0;
      do_zero[j] = 1'b0;
      if (enc_mode == ENC_LEGACY) begin
        do_sub[j] = active;
      end else if (enc_mode == ENC_PLAIN) begin
        do_sub[j]  = active;
        do_zero[j] = !active;
      end else if (!active) begin
        do_zero[j] = 1'b1;
      end else if (!mask_on || wr_mask[j]) begin
        do_sub[j] = 1'b1;
      end else begin
        do_zero[j] = zero_fill;
      end
    end
  end
endmodule

// File: rtl/psq_lane.sv
// One 64-bit element: operand select, wrapping subtract, fill policy.
module psq_lane #(
  parameter int unsigned W = psq_pkg::ELEM_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] b_scalar,
  input  logic [W-1:0] old,
  input  logic         use_scalar,
  input  logic         do_sub,
  input  logic         do_zero,
  output logic [W-1:0] y
);
  logic [W-1:0] b_sel;
  logic [W-1:0] diff;

  always_comb begin
    b_sel = use_scalar ? b_scalar : b;
    diff  = a - b_sel;
    if (do_sub)       y = diff;
    else if (do_zero) y = '0;
    else              y = old;
  end

  // R1: a computed lane must invert back to the minuend modulo 2^W
  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    do_sub |-> ((y + b_sel) == a));
endmodule

// File: rtl/masked_qsub.sv
module masked_qsub #(
  parameter int unsigned ELEM_W  = psq_pkg::ELEM_W,
  parameter int unsigned N_ELEMS = psq_pkg::MAX_ELEMS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [ELEM_W*N_ELEMS-1:0] src_a,
  input  logic [ELEM_W*N_ELEMS-1:0] src_b,
  input  logic [ELEM_W*N_ELEMS-1:0] dst_old,
  input  logic [N_ELEMS-1:0]        wr_mask,
  input  logic                      mask_on,
  input  logic                      zero_fill,
  input  logic                      bcast,
  input  logic                      src_b_mem,
  input  logic [1:0]                enc_mode,
  input  logic [1:0]                vec_len,
  output logic [ELEM_W*N_ELEMS-1:0] result,
  output logic                      res_valid
);
  import psq_pkg::*;

  localparam int unsigned DATA_W = ELEM_W * N_ELEMS;
  localparam int unsigned LEG_W  = ELEM_W * LEG_ELEMS;

  logic [N_ELEMS-1:0] do_sub;
  logic [N_ELEMS-1:0] do_zero;
  logic               use_scalar;
  logic [DATA_W-1:0]  lanes;
  logic [DATA_W-1:0]  res_d, res_q;
  logic               vld_d, vld_q;

  psq_ctrl #(.N_ELEMS(N_ELEMS)) u_ctrl (
    .enc_mode  (enc_mode),
    .vec_len   (vec_len),
    .wr_mask   (wr_mask),
    .mask_on   (mask_on),
    .zero_fill (zero_fill),
    .bcast     (bcast),
    .src_b_mem (src_b_mem),
    .do_sub    (do_sub),
    .do_zero   (do_zero),
    .use_scalar(use_scalar)
  );

  for (genvar j = 0; j < N_ELEMS; j++) begin : g_lane
    psq_lane #(.W(ELEM_W)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .a         (src_a[j*ELEM_W +: ELEM_W]),
      .b         (src_b[j*ELEM_W +: ELEM_W]),
      .b_scalar  (src_b[ELEM_W-1:0]),
      .old       (dst_old[j*ELEM_W +: ELEM_W]),
      .use_scalar(use_scalar),
      .do_sub    (do_sub[j]),
      .do_zero   (do_zero[j]),
      .y         (lanes[j*ELEM_W +: ELEM_W])
    );
  end

  // next state, with the load enable written out
  always_comb begin
    vld_d = in_valid;
    res_d = res_q;
    if (in_valid) res_d = lanes;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      res_q <= res_d;
      vld_q <= vld_d;
    end
  end

  assign result    = res_q;
  assign res_valid = vld_q;

  p_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!res_valid && $stable(res_q)));

  p_legacy_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && enc_mode == ENC_LEGACY)
      |=> (res_q[DATA_W-1:LEG_W] == $past(dst_old[DATA_W-1:LEG_W])));

  // R8: a 128-bit length outside legacy clears everything above bit 127
  p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && enc_mode != ENC_LEGACY && vec_len == 2'd0)
      |=> (res_q[DATA_W-1:LEG_W] == '0));
endmodule

// File: tb/tb_masked_qsub.sv
module tb_masked_qsub;
  localparam int EW = 64;
  localparam int NE = 8;
  localparam int DW = EW * NE;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [DW-1:0] src_a, src_b, dst_old;
  logic [NE-1:0] wr_mask;
  logic          mask_on, zero_fill, bcast, src_b_mem;
  logic [1:0]    enc_mode, vec_len;
  logic [DW-1:0] result;
  logic          res_valid;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  masked_qsub dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
    .wr_mask(wr_mask), .mask_on(mask_on), .zero_fill(zero_fill),
    .bcast(bcast), .src_b_mem(src_b_mem),
    .enc_mode(enc_mode), .vec_len(vec_len),
    .result(result), .res_valid(res_valid)
  );

  typedef struct packed {
    logic [1:0] mode;
    logic [1:0] vl;
    logic [7:0] m;
    logic       me;
    logic       zp;
    logic       bc;
    logic       bm;
    logic [7:0] seed;
    logic [3:0] req;
  } vec_t;

  // mode, len, mask, mask_on, zero_fill, bcast, b_mem, seed, requirement
  localparam vec_t TBL [16] = '{
    '{2'd0, 2'd2, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, 8'd3,  4'd3},  // R3
    '{2'd0, 2'd0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 8'd7,  4'd10}, // R10
    '{2'd1, 2'd0, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 8'd11, 4'd4},  // R4
    '{2'd1, 2'd1, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'd13, 4'd4},  // R4
    '{2'd1, 2'd2, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 8'd17, 4'd10}, // R10
    '{2'd2, 2'd2, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, 8'd19, 4'd5},  // R5
    '{2'd2, 2'd2, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'd23, 4'd5},  // R5
    '{2'd2, 2'd2, 8'hA5, 1'b1, 1'b0, 1'b0, 1'b0, 8'd29, 4'd6},  // R6
    '{2'd2, 2'd2, 8'h5A, 1'b1, 1'b1, 1'b0, 1'b0, 8'd31, 4'd7},  // R7
    '{2'd2, 2'd0, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, 8'd37, 4'd8},  // R8
    '{2'd2, 2'd1, 8'hF3, 1'b1, 1'b0, 1'b0, 1'b0, 8'd41, 4'd8},  // R8
    '{2'd2, 2'd2, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b1, 8'd43, 4'd9},  // R9
    '{2'd3, 2'd1, 8'h0B, 1'b1, 1'b1, 1'b1, 1'b1, 8'd47, 4'd9},  // R9
    '{2'd2, 2'd2, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0, 8'd53, 4'd10}, // R10
    '{2'd3, 2'd3, 8'hC3, 1'b1, 1'b0, 1'b0, 1'b0, 8'd59, 4'd2},  // R2
    '{2'd1, 2'd3, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'd61, 4'd2}   // R2
  };

  function automatic logic [DW-1:0] gen_a(input logic [7:0] s);
    logic [DW-1:0] v;
    for (int j = 0; j < NE; j++)
      v[j*EW +: EW] = 64'(s) * 64'h9E37_79B9_7F4A_7C15 + 64'(j) * 64'h0000_0001_0000_0003;
    return v;
  endfunction

  function automatic logic [DW-1:0] gen_b(input logic [7:0] s);
    logic [DW-1:0] v;
    for (int j = 0; j < NE; j++)
      v[j*EW +: EW] = (64'(s) * 64'hC2B2_AE3D_27D4_EB4F) ^ (64'(j + 1) << 40);
    return v;
  endfunction

  function automatic logic [DW-1:0] gen_old(input logic [7:0] s);
    logic [DW-1:0] v;
    for (int j = 0; j < NE; j++)
      v[j*EW +: EW] = 64'hD0D0_0000_0000_0000 | (64'(s) << 8) | 64'(j);
    return v;
  endfunction

  // Expected result, written from the requirements
  function automatic logic [DW-1:0] model(
    input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [DW-1:0] o,
    input logic [1:0] mode, input logic [1:0] vl, input logic [7:0] m,
    input logic me, input logic zp, input logic bc, input logic bm);
    logic [DW-1:0] r;
    int   cnt;
    logic [EW-1:0] bs, d;
    cnt = (vl == 2'd0) ? 2 : (vl == 2'd1) ? 4 : 8;
    for (int j = 0; j < NE; j++) begin
      bs = (mode >= 2'd2 && bc && bm) ? b[EW-1:0] : b[j*EW +: EW];
      d  = a[j*EW +: EW] - bs;
      if (mode == 2'd0)
        r[j*EW +: EW] = (j < 2) ? d : o[j*EW +: EW];
      else if (mode == 2'd1)
        r[j*EW +: EW] = (j < cnt) ? d : '0;
      else if (j >= cnt)
        r[j*EW +: EW] = '0;
      else if (!me || m[j])
        r[j*EW +: EW] = d;
      else
        r[j*EW +: EW] = zp ? '0 : o[j*EW +: EW];
    end
    return r;
  endfunction

  task automatic chk_vec(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic apply(
    input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [DW-1:0] o,
    input logic [1:0] mode, input logic [1:0] vl, input logic [7:0] m,
    input logic me, input logic zp, input logic bc, input logic bm);
    @(negedge clk);
    src_a = a; src_b = b; dst_old = o;
    enc_mode = mode; vec_len = vl; wr_mask = m;
    mask_on = me; zero_fill = zp; bcast = bc; src_b_mem = bm;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] a, b, o, e, held;
    rst_n = 1'b0; in_valid = 1'b0;
    src_a = '0; src_b = '0; dst_old = '0; wr_mask = '0;
    mask_on = 1'b0; zero_fill = 1'b0; bcast = 1'b0; src_b_mem = 1'b0;
    enc_mode = 2'd0; vec_len = 2'd0;
    repeat (3) @(negedge clk);
    chk_vec("R12 reset result", result, '0);
    chk_bit("R12 reset valid", res_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_bit("R11 idle valid after reset", res_valid, 1'b0);

    for (int i = 0; i < 16; i++) begin
      a = gen_a(TBL[i].seed); b = gen_b(TBL[i].seed); o = gen_old(TBL[i].seed);
      e = model(a, b, o, TBL[i].mode, TBL[i].vl, TBL[i].m,
                TBL[i].me, TBL[i].zp, TBL[i].bc, TBL[i].bm);
      apply(a, b, o, TBL[i].mode, TBL[i].vl, TBL[i].m,
            TBL[i].me, TBL[i].zp, TBL[i].bc, TBL[i].bm);
      chk_vec($sformatf("R%0d vector %0d", TBL[i].req, i), result, e);
      chk_bit($sformatf("R11 valid vector %0d", i), res_valid, 1'b1);
    end

    // R1: wrap corners, 0-1 and most-negative minus 1, alternating per element
    a = '0; b = '0; o = gen_old(8'd99);
    for (int j = 0; j < NE; j++) begin
      a[j*EW +: EW] = (j % 2 == 0) ? 64'h0 : 64'h8000_0000_0000_0000;
      b[j*EW +: EW] = 64'h1;
    end
    apply(a, b, o, 2'd1, 2'd2, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    e = '0;
    for (int j = 0; j < NE; j++)
      e[j*EW +: EW] = (j % 2 == 0) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h7FFF_FFFF_FFFF_FFFF;
    chk_vec("R1 wrap corners", result, e);
    held = result;

    // R11: inputs change without a request; result must hold, valid low
    @(negedge clk);
    src_a = gen_a(8'd5); src_b = gen_b(8'd6); enc_mode = 2'd2;
    @(negedge clk);
    chk_vec("R11 hold without request", result, held);
    chk_bit("R11 valid low when idle", res_valid, 1'b0);

    // R9: broadcast with a lane whose own element differs from element 0
    a = gen_a(8'd71); b = gen_b(8'd72); o = gen_old(8'd73);
    apply(a, b, o, 2'd2, 2'd2, 8'h81, 1'b1, 1'b1, 1'b1, 1'b1);
    e = '0;
    e[EW-1:0]           = a[EW-1:0] - b[EW-1:0];
    e[7*EW +: EW]       = a[7*EW +: EW] - b[EW-1:0];
    chk_vec("R9 broadcast mask 0x81 zero fill", result, e);

    // R12: asynchronous reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_vec("R12 mid-run reset result", result, '0);
    chk_bit("R12 mid-run reset valid", res_valid, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule